// File: doc/BRIEF.md
# Adaptive-Depth Hard-Decision Viterbi Decoder

This block recovers the information bits of a rate one-half, constraint length three convolutional code from a stream of received hard-decision code pairs. One pair is accepted on every cycle where `in_valid` is high. For each pair the block forms Hamming branch metrics and runs add-compare-select over the four trellis states. The four path metrics are re-based every step so that their minimum is zero. The one-bit decisions are kept in a survivor shift store. A traceback then starts from the state that holds the lowest metric and yields one decoded bit per accepted pair.

The traceback depth is either 4 or 15 trellis steps. A channel-quality figure `snr_db`, in whole decibels, is compared with a threshold of 6 dB. A noisy channel (below the threshold) gets the deep traceback, which decodes more accurately. A clean channel gets the shallow one, which has lower latency. The comparison is sampled only at reset or on a synchronous `flush`. A flush also clears the trellis and the survivor history, so a new depth always starts from a known, empty state. On equal candidate sums, the path from the lower-numbered predecessor is kept. When several states share the lowest metric, traceback starts from the lowest-numbered one.

Top module: `viterbi_adaptive_dec`

## Requirements
- R1: The code is defined as follows. The state is the previous two input bits {u(t-1), u(t-2)}, and it is zero after reset or flush. Pair bit [1] is u ^ u(t-1) ^ u(t-2), from generator 7 octal. Pair bit [0] is u ^ u(t-2), from generator 5 octal. An error-free stream of this code is decoded without error in both depth modes.
- R2: In deep mode, a single flipped code bit is corrected when no other flipped bit lies within 10 pairs of it.
- R3: Path metrics never overflow. After every accepted pair the smallest metric is zero and no metric exceeds the initial bias plus 2. This holds for streams of any length, including ones carrying many errors.
- R4: The decoded bit for the k-th accepted pair appears on `out_bit` with `out_valid` in the cycle after pair k+TL is accepted, where TL is the active depth. After reset or flush, the first `out_valid` therefore follows pair TL+1.
- R5: The depth is 15 when `snr_db` < 6 and 4 when `snr_db` >= 6, so a value of exactly 6 selects depth 4. `snr_db` is sampled while reset is asserted and in the cycle where `flush` is high.
- R6: A change of `snr_db` without a flush has no effect on latency or on the decoded bits.
- R7: In the cycle after `flush`, `out_valid` is low. After a flush the metrics and the survivor history start afresh. A pair presented together with `flush` is discarded.
- R8: After reset, `out_valid` is low, state 0 holds metric zero and every other state holds the initial bias (16).
- R9: `out_valid` is high only in the cycle after an accepted pair. Once the store is filled, every accepted pair produces exactly one decoded bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received code pair is present this cycle |
| in_code | input | 2 | Received hard bits: [1] for generator 7, [0] for generator 5 |
| flush | input | 1 | Synchronous restart; latches the depth mode from `snr_db` |
| snr_db | input | 8 | Channel quality in dB, unsigned |
| out_valid | output | 1 | `out_bit` carries a decoded bit this cycle |
| out_bit | output | 1 | Decoded information bit |

## Verification
The bench targets the 6 dB boundary. A design that compared with less-or-equal would pick the deep mode at exactly 6 and deliver its first bit eleven pairs late. The bench changes `snr_db` in the middle of a stream and sends a pair together with `flush`. A decoder that re-read the mode on the fly would shift its latency mid-stream, and one that accepted the flushed pair would decode a corrupted, displaced sequence. A run of several hundred pairs, with an error every twelve pairs, pushes un-normalized metrics past six bits. Without normalization the metrics wrap, the wrong survivors win, and decoded bits are lost.

// File: rtl/vdec_pkg.sv
// Package vdec_pkg
// Shared trellis types and the code-pair function for the four-state,
// rate one-half decoder. Assumes constraint length three: the state is
// the two previous input bits {u(t-1), u(t-2)}.
package vdec_pkg;

    localparam int unsigned NUM_ST = 4;
    localparam int unsigned ST_W   = 2;

    typedef logic [ST_W-1:0]   state_t;
    typedef logic [NUM_ST-1:0] dec_vec_t;
    typedef logic [1:0]        bm_t;

    // Code pair emitted when input u leaves state s; bit [1] from gen_a.
    function automatic logic [1:0] pair_of(input logic [2:0] gen_a,
                                           input logic [2:0] gen_b,
                                           input state_t     s,
                                           input logic       u);
        logic [2:0] win;
        win = {u, s};
        return {^(win & gen_a), ^(win & gen_b)};
    endfunction

endpackage

// File: rtl/vdec_bmu.sv
// Module vdec_bmu
// Hard-decision branch metric unit: for each of the four possible code
// pairs, the Hamming distance (0..2) to the received pair.
// Assumes the received pair is already a hard decision.
module vdec_bmu
    import vdec_pkg::*;
(
    input  logic [1:0]      rx_pair,
    output bm_t  [3:0]      bm
);

    for (genvar c = 0; c < 4; c++) begin : g_hyp
        localparam logic [1:0] HYP = 2'(c);
        logic [1:0] diff;
        // Count the mismatching bits against this hypothesis.
        always_comb begin
            diff  = rx_pair ^ HYP;
            bm[c] = {1'b0, diff[1]} + {1'b0, diff[0]};
        end
    end

endmodule

// File: rtl/vdec_acs.sv
// Module vdec_acs
// Add-compare-select over four states, radix two, with per-step
// normalization (the minimum metric is subtracted after every step).
// Assumes next state {u, s[1]}; the predecessors of state n are
// {n[0],0} and {n[0],1}. A tie keeps the lower-numbered predecessor.
// Also reports the lowest-numbered state holding the minimum metric.
module vdec_acs
    import vdec_pkg::*;
#(
    parameter int unsigned PM_W        = 6,
    parameter int unsigned INIT_METRIC = 16,
    parameter logic [2:0]  GEN_A       = 3'b111,
    parameter logic [2:0]  GEN_B       = 3'b101
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          step,
    input  bm_t      [3:0]                bm,
    output logic     [NUM_ST-1:0][PM_W-1:0] pm_q,
    output dec_vec_t                      dec,
    output state_t                        best_st
);

    localparam logic [PM_W-1:0] BIAS = PM_W'(INIT_METRIC);

    logic [NUM_ST-1:0][PM_W-1:0] raw;
    logic [NUM_ST-1:0][PM_W-1:0] norm;
    logic [PM_W-1:0]             raw_min;

    for (genvar ns = 0; ns < NUM_ST; ns++) begin : g_node
        localparam int unsigned PA     = (ns % 2) * 2;
        localparam int unsigned PB     = PA + 1;
        localparam logic        U_BIT  = logic'(ns / 2);
        localparam logic [1:0]  CODE_A = pair_of(GEN_A, GEN_B, state_t'(PA), U_BIT);
        localparam logic [1:0]  CODE_B = pair_of(GEN_A, GEN_B, state_t'(PB), U_BIT);
        logic [PM_W-1:0] cand_a;
        logic [PM_W-1:0] cand_b;
        // Extend both candidate paths and keep the cheaper (lower wins ties).
        always_comb begin
            cand_a  = pm_q[PA] + {{(PM_W-2){1'b0}}, bm[CODE_A]};
            cand_b  = pm_q[PB] + {{(PM_W-2){1'b0}}, bm[CODE_B]};
            dec[ns] = (cand_b < cand_a);
            raw[ns] = dec[ns] ? cand_b : cand_a;
        end
    end

    // Find the smallest new metric for re-basing.
    always_comb begin
        raw_min = raw[0];
        for (int s = 1; s < NUM_ST; s++) begin
            if (raw[s] < raw_min) raw_min = raw[s];
        end
        for (int s = 0; s < NUM_ST; s++) begin
            norm[s] = raw[s] - raw_min;
        end
    end

    // Hold the normalized metrics; restart from the zero state on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int s = 0; s < NUM_ST; s++) begin
                pm_q[s] <= (s == 0) ? '0 : BIAS;
            end
        end else if (step) begin
            pm_q <= norm;
        end
    end

    // Pick the lowest-numbered state with the smallest stored metric.
    always_comb begin
        logic [PM_W-1:0] m;
        m       = pm_q[0];
        best_st = '0;
        for (int s = 1; s < NUM_ST; s++) begin
            if (pm_q[s] < m) begin
                m       = pm_q[s];
                best_st = state_t'(s);
            end
        end
    end

endmodule

// File: rtl/vdec_survivor.sv
// Module vdec_survivor
// Survivor decision store plus a combinational traceback chain.
// Assumes decision d of state n selects predecessor {n[0], d}. Because
// the decoded bit is bit 0 of the state one step short of the full
// depth, a depth TL needs only TL-1 stored decision columns.
module vdec_survivor
    import vdec_pkg::*;
#(
    parameter int unsigned TL_SHORT = 4,
    parameter int unsigned TL_LONG  = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  logic     step,
    input  dec_vec_t dec_in,
    input  state_t   start_st,
    input  logic     long_sel,
    output logic     bit_out
);

    localparam int unsigned DEPTH = TL_LONG - 1;

    dec_vec_t [DEPTH-1:0] sv_q;
    state_t   [DEPTH-1:0] walk;
    logic     [DEPTH-1:0] tip;

    // Shift in the newest decision column; empty the store on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sv_q <= '0;
        end else if (step) begin
            sv_q <= {sv_q[DEPTH-2:0], dec_in};
        end
    end

    assign walk[0] = start_st;

    for (genvar k = 0; k < DEPTH; k++) begin : g_walk
        // Read the decision of the state reached k steps back.
        assign tip[k] = sv_q[k][walk[k]];
        if (k < DEPTH - 1) begin : g_link
            assign walk[k+1] = {walk[k][0], tip[k]};
        end
    end

    // Choose the decoded bit for the active depth.
    assign bit_out = long_sel ? tip[TL_LONG-2] : tip[TL_SHORT-2];

endmodule

// File: rtl/viterbi_adaptive_dec.sv
// Module viterbi_adaptive_dec
// Top of the adaptive-depth hard-decision Viterbi decoder. It accepts one
// code pair per valid cycle and emits one decoded bit per pair once the
// survivor store holds enough steps for the active depth. The depth is
// latched from snr_db at reset and at flush only.
// Assumes a rate one-half, constraint-length-three code that starts in
// state zero.
module viterbi_adaptive_dec
    import vdec_pkg::*;
#(
    parameter int unsigned PM_W          = 6,
    parameter int unsigned INIT_METRIC   = 16,
    parameter int unsigned TL_SHORT      = 4,
    parameter int unsigned TL_LONG       = 15,
    parameter int unsigned SNR_W         = 8,
    parameter int unsigned SNR_THRESH_DB = 6,
    parameter logic [2:0]  GEN_A         = 3'b111,
    parameter logic [2:0]  GEN_B         = 3'b101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_code,
    input  logic             flush,
    input  logic [SNR_W-1:0] snr_db,
    output logic             out_valid,
    output logic             out_bit
);

    localparam int unsigned      FILL_MAX   = TL_LONG + 1;
    localparam int unsigned      FILL_W     = $clog2(FILL_MAX + 1);
    localparam logic [FILL_W-1:0] FILL_TOP  = FILL_W'(FILL_MAX);
    localparam logic [FILL_W-1:0] NEED_SHORT = FILL_W'(TL_SHORT + 1);
    localparam logic [FILL_W-1:0] NEED_LONG  = FILL_W'(TL_LONG + 1);
    localparam logic [SNR_W-1:0]  THRESH    = SNR_W'(SNR_THRESH_DB);

    logic                        step;
    logic                        long_q;
    logic [FILL_W-1:0]           fill_q;
    logic [FILL_W-1:0]           fill_next;
    logic [FILL_W-1:0]           need;
    logic                        out_valid_q;
    bm_t      [3:0]              bm;
    logic [NUM_ST-1:0][PM_W-1:0] pm_q;
    dec_vec_t                    dec;
    state_t                      best_st;

    // A pair is taken only when no flush competes with it.
    assign step = in_valid && !flush;

    // Latch the depth mode from the channel figure at reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            long_q <= (snr_db < THRESH);
        end
    end

    // Count stored steps, saturating once the deepest window is full.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fill_q <= '0;
        end else if (step && fill_q != FILL_TOP) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign fill_next = (fill_q == FILL_TOP) ? fill_q : fill_q + 1'b1;
    assign need      = long_q ? NEED_LONG : NEED_SHORT;

    // Raise the output strobe for a pair that completes a full window.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= step && (fill_next >= need);
        end
    end

    assign out_valid = out_valid_q;

    vdec_bmu u_bmu (
        .rx_pair (in_code),
        .bm      (bm)
    );

    vdec_acs #(
        .PM_W        (PM_W),
        .INIT_METRIC (INIT_METRIC),
        .GEN_A       (GEN_A),
        .GEN_B       (GEN_B)
    ) u_acs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush),
        .step    (step),
        .bm      (bm),
        .pm_q    (pm_q),
        .dec     (dec),
        .best_st (best_st)
    );

    vdec_survivor #(
        .TL_SHORT (TL_SHORT),
        .TL_LONG  (TL_LONG)
    ) u_surv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (flush),
        .step     (step),
        .dec_in   (dec),
        .start_st (best_st),
        .long_sel (long_q),
        .bit_out  (out_bit)
    );

endmodule

// File: rtl/viterbi_adaptive_dec_chk.sv
// Module viterbi_adaptive_dec_chk
// Property checker bound to viterbi_adaptive_dec. It watches the metric
// registers, the latched depth mode and the output strobe.
// Assumes the four-state metric array of the top.
module viterbi_adaptive_dec_chk #(
    parameter int unsigned PM_W        = 6,
    parameter int unsigned INIT_METRIC = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 flush,
    input logic                 out_valid,
    input logic                 long_q,
    input logic [3:0][PM_W-1:0] pm_q
);

    localparam logic [PM_W-1:0] BIAS  = PM_W'(INIT_METRIC);
    localparam logic [PM_W-1:0] LIMIT = PM_W'(INIT_METRIC + 2);

    // R3: after an accepted pair some state sits at metric zero
    a_r3_metric_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !flush) |->
            (pm_q[0] == '0 || pm_q[1] == '0 || pm_q[2] == '0 || pm_q[3] == '0));

    // R3: metrics stay under the bound, far below the register limit
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_q[0] <= LIMIT && pm_q[1] <= LIMIT && pm_q[2] <= LIMIT && pm_q[3] <= LIMIT));

    // R6: the depth mode moves only through reset or flush
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flush)) |-> $stable(long_q));

    // R7: no decoded bit in the cycle after a flush
    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !out_valid);

    // R8: leaving reset, the metrics hold the zero-state start values
    a_r8_reset_metrics: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pm_q[0] == '0 && pm_q[1] == BIAS &&
                           pm_q[2] == BIAS && pm_q[3] == BIAS && !out_valid));

    // R9: the strobe only follows an accepted pair
    a_r9_valid_follows_pair: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !flush));

endmodule

bind viterbi_adaptive_dec viterbi_adaptive_dec_chk #(
    .PM_W        (PM_W),
    .INIT_METRIC (INIT_METRIC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .flush     (flush),
    .out_valid (out_valid),
    .long_q    (long_q),
    .pm_q      (pm_q)
);

// File: tb/viterbi_adaptive_dec_tb.sv
// Bench for viterbi_adaptive_dec: a reference encoder feeds table-driven
// streams, then directed tests cover reset, boundary and flush cases.
module viterbi_adaptive_dec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 6;
    // Each entry: {snr_db[7:0], message[15:0], error mask[15:0]}
    localparam logic [39:0] VEC_TAB [N_VEC] = '{
        {8'd10, 16'hB4E1, 16'h0000},
        {8'd20, 16'h0000, 16'h0000},
        {8'd6,  16'hFFFF, 16'h0000},
        {8'd3,  16'h5A3C, 16'h0000},
        {8'd0,  16'hC3A5, 16'h1004},
        {8'd5,  16'h9F21, 16'h0040}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_code = 2'b00;
    logic       flush = 1'b0;
    logic [7:0] snr_db = 8'd3;
    logic       out_valid;
    logic       out_bit;

    int n_checks = 0;
    int n_fail   = 0;
    int n_out;
    int first_out;
    int pair_cnt;
    logic [1023:0] msg_bits;
    logic [1023:0] err_bits;
    logic [1023:0] dec_bits;

    always #(CLK_PERIOD/2) clk = ~clk;

    viterbi_adaptive_dec u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .flush     (flush),
        .snr_db    (snr_db),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_pair(input logic [1:0] c);
        in_valid = 1'b1;
        in_code  = c;
        @(negedge clk);
        pair_cnt++;
        if (out_valid) begin
            if (n_out == 0) first_out = pair_cnt;
            if (n_out < 1024) dec_bits[n_out] = out_bit;
            n_out++;
        end
    endtask

    // Encode msg_bits (generators 7 and 5) plus a zero tail of tl pairs.
    task automatic run_stream(input int len, input int tl, input int chg_at);
        logic [1:0] s;
        logic [1:0] c;
        logic       u;
        s = 2'b00;
        n_out = 0;
        first_out = 0;
        pair_cnt = 0;
        for (int i = 0; i < len + tl; i++) begin
            u = (i < len) ? msg_bits[i] : 1'b0;
            c = {u ^ s[1] ^ s[0], u ^ s[0]};
            s = {u, s[1]};
            if (i < len && err_bits[i]) c[1] = ~c[1];
            if (i == chg_at) snr_db = 8'd1;
            send_pair(c);
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_flush(input logic [7:0] snr, input logic with_pair);
        flush    = 1'b1;
        snr_db   = snr;
        in_valid = with_pair;
        in_code  = 2'b11;
        @(negedge clk);
        flush    = 1'b0;
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R7", "out_valid after flush", out_valid, 0);
    endtask

    function automatic int mismatches(input int len);
        int m = 0;
        for (int j = 0; j < len; j++) begin
            if (dec_bits[j] !== msg_bits[j]) m++;
        end
        return m;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int tl;
        logic [15:0] lfsr;
        // Reset with a noisy channel figure: the deep mode must be latched (R8, R5).
        rst_n  = 1'b0;
        snr_db = 8'd3;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        msg_bits = '0;
        err_bits = '0;
        msg_bits[15:0] = 16'h2D71;
        run_stream(16, 15, -1);
        check(first_out == 16, "R5", "first output after reset, snr 3", first_out, 16);
        check(mismatches(16) == 0, "R1", "decode after reset", mismatches(16), 0);

        // Table of streams: snr picks the depth, errors only in deep mode.
        for (int v = 0; v < N_VEC; v++) begin
            tl = (VEC_TAB[v][39:32] < 8'd6) ? 15 : 4;
            msg_bits = '0;
            err_bits = '0;
            msg_bits[15:0] = VEC_TAB[v][31:16];
            err_bits[15:0] = VEC_TAB[v][15:0];
            do_flush(VEC_TAB[v][39:32], 1'b0);
            run_stream(16, tl, -1);
            check(first_out == tl + 1, "R4", "first output pair (R5 depth)", first_out, tl + 1);
            check(n_out == 16, "R9", "decoded bit count", n_out, 16);
            if (VEC_TAB[v][15:0] != 16'h0000)
                check(mismatches(16) == 0, "R2", "single errors corrected", mismatches(16), 0);
            else
                check(mismatches(16) == 0, "R1", "error-free decode", mismatches(16), 0);
        end

        // R6: snr drops below threshold mid-stream without a flush.
        msg_bits = '0;
        err_bits = '0;
        msg_bits[15:0] = 16'h6B93;
        do_flush(8'd9, 1'b0);
        run_stream(16, 4, 3);
        check(first_out == 5, "R6", "latency unchanged by snr change", first_out, 5);
        check(mismatches(16) == 0, "R6", "decode unchanged by snr change", mismatches(16), 0);

        // R7: a pair presented with flush is dropped.
        msg_bits[15:0] = 16'hE00D;
        do_flush(8'd12, 1'b1);
        run_stream(16, 4, -1);
        check(first_out == 5, "R7", "flushed pair not counted", first_out, 5);
        check(mismatches(16) == 0, "R7", "flushed pair not decoded", mismatches(16), 0);

        // R3: long noisy stream; errors every 12 pairs in deep mode.
        msg_bits = '0;
        err_bits = '0;
        lfsr = 16'hACE1;
        for (int i = 0; i < 900; i++) begin
            msg_bits[i] = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 12 == 5) err_bits[i] = 1'b1;
        end
        do_flush(8'd2, 1'b0);
        run_stream(900, 15, -1);
        check(n_out == 900, "R9", "long stream bit count", n_out, 900);
        check(mismatches(900) == 0, "R3", "long noisy stream decode", mismatches(900), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule